// File: doc/BRIEF.md
# Autobaud Bit-Period Detector

This block finds the bit rate of a serial line from the first character that arrives while the line is idle. The sender is expected to open with a character whose first data bit is 1, so the first low pulse on the line is exactly one start bit. The detector counts sample ticks while that start bit lasts. It turns the count into a bit-period divisor for the transmitter and a first-sample delay for the receiver, and it selects a separate fast-rate mode when the pulse is shorter than two ticks.

The asynchronous receive line goes through a flop synchronizer before it is counted. While the detector waits, it drives the two modem handshake outputs (clear-to-send and data-set-ready) high to invite traffic. When the low pulse ends, it raises the channel enable, emits a one-cycle lock pulse and freezes its results. Only a synchronous reset starts a new measurement.

Control is a three-state machine:
- `ST_HUNT` waits for a tick that sees the line low. Transition T_START leads to `ST_MEASURE`.
- `ST_MEASURE` counts the low ticks. Transition T_CLOSE happens on the first tick that sees the line high and leads to `ST_LOCKED`.
- `ST_LOCKED` holds its results.
- Transition T_RESET returns from any state to `ST_HUNT`.

Top module: `autobaud_detector`

## Requirements
- R1: While reset is high and in the cycle after reset, `chan_enable`, `lock_pulse` and `fast_mode` are 0, `bit_divisor` and `rx_first_delay` are 0, and `cts_out` and `dsr_out` are 1.
- R2: `cts_out` and `dsr_out` are 1 in `ST_HUNT` and `ST_MEASURE`, and 0 once the detector is in `ST_LOCKED`.
- R3: The measured count is the number of `tick` cycles in which the synchronized line is low. The first such tick takes T_START and counts 1. Cycles without `tick` never count.
- R4: The first tick that sees the synchronized line high while in `ST_MEASURE` takes T_CLOSE. On the next clock edge `chan_enable` rises, and `lock_pulse` is high for exactly that one cycle.
- R5: For a measured count C of 2 or more, `bit_divisor` is C-1, `rx_first_delay` is (C-1)/2 rounded down, and `fast_mode` is 0.
- R6: For a measured count of 1, `fast_mode` is 1, `bit_divisor` is 1 and `rx_first_delay` is 1.
- R7: The count saturates at 0xFFFF instead of wrapping. A pulse of 65535 ticks or longer gives `bit_divisor` 0xFFFE and `rx_first_delay` 0x7FFF.
- R8: After lock, further activity on `rxd_in` and `tick` does not change `bit_divisor`, `rx_first_delay`, `fast_mode` or `chan_enable`, and it gives no new `lock_pulse`.
- R9: A synchronous reset in the same cycle as the closing tick wins: no lock happens. After reset, a new measurement starts from a count of zero.
- R10: Ticks that see the line high in `ST_HUNT` do not count and do not start a measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Sample-tick enable, one cycle per sample |
| rxd_in | input | 1 | Asynchronous serial receive line, idle high |
| bit_divisor | output | CNT_W | Bit period in ticks, for the transmitter |
| rx_first_delay | output | CNT_W | Receiver first-sample preload |
| fast_mode | output | 1 | Fast-rate mode selected |
| chan_enable | output | 1 | Channel enabled, measurement locked |
| lock_pulse | output | 1 | One-cycle pulse when the lock happens |
| cts_out | output | 1 | Clear-to-send, high while waiting |
| dsr_out | output | 1 | Data-set-ready, high while waiting |

## Verification
Two functions can fall in the same cycle: the synchronous reset and the closing tick that would lock the channel. The bench provokes this by raising `rst` and `tick` together on the cycle the line has returned high after a low pulse. It then judges the outcome at the ports: no lock pulse, enable still low, divisor still zero and handshakes still high. A second pulse measured afterwards must give a divisor based only on its own length. A second overlap is a line that stays low past saturation. In that case the closing tick meets a count already held at its maximum, and the bench expects the clipped divisor.

// File: rtl/abd_pkg.sv
package abd_pkg;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_MEASURE = 2'd1,
        ST_LOCKED  = 2'd2
    } abd_state_e;

endpackage

// File: rtl/abd_sync.sv
module abd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= 1'b1;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/abd_satcnt.sv
module abd_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         at_max
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    assign at_max = (value == MAXV);

    always_ff @(posedge clk) begin
        if (rst)
            value <= '0;
        else if (inc && !at_max)
            value <= value + W'(1);
    end
endmodule

// File: rtl/abd_result.sv
module abd_result #(
    parameter int W          = 16,
    parameter int FAST_LIMIT = 2
) (
    input  logic [W-1:0] measured,
    output logic [W-1:0] divisor,
    output logic [W-1:0] half_delay,
    output logic         fast
);
    localparam logic [W-1:0] LIMIT = W'(FAST_LIMIT);

    always_comb begin
        fast = (measured < LIMIT);
        if (fast) begin
            divisor    = measured;
            half_delay = W'(1);
        end else begin
            divisor    = measured - W'(1);
            half_delay = divisor >> 1;
        end
    end
endmodule

// File: rtl/autobaud_detector.sv
module autobaud_detector
    import abd_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FAST_LIMIT  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             rxd_in,
    output logic [CNT_W-1:0] bit_divisor,
    output logic [CNT_W-1:0] rx_first_delay,
    output logic             fast_mode,
    output logic             chan_enable,
    output logic             lock_pulse,
    output logic             cts_out,
    output logic             dsr_out
);
    abd_state_e       state_q, state_d;
    logic             rxd_s;
    logic             cnt_inc;
    logic             cnt_at_max;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] res_div;
    logic [CNT_W-1:0] res_half;
    logic             res_fast;
    logic             close_hit;

    abd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rxd_in),
        .q   (rxd_s)
    );

    abd_satcnt #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .inc    (cnt_inc),
        .value  (cnt_val),
        .at_max (cnt_at_max)
    );

    abd_result #(.W(CNT_W), .FAST_LIMIT(FAST_LIMIT)) u_res (
        .measured   (cnt_val),
        .divisor    (res_div),
        .half_delay (res_half),
        .fast       (res_fast)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HUNT;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d   = state_q;
        cnt_inc   = 1'b0;
        close_hit = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (tick && !rxd_s) begin
                    cnt_inc = 1'b1;
                    state_d = ST_MEASURE;
                end
            end
            ST_MEASURE: begin
                if (tick && !rxd_s) begin
                    cnt_inc = 1'b1;
                end else if (tick && rxd_s) begin
                    close_hit = 1'b1;
                    state_d   = ST_LOCKED;
                end
            end
            ST_LOCKED: begin
                state_d = ST_LOCKED;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // handshake outputs
    always_comb begin
        cts_out = (state_q != ST_LOCKED);
        dsr_out = (state_q != ST_LOCKED);
    end

    // locked results
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_divisor    <= '0;
            rx_first_delay <= '0;
            fast_mode      <= 1'b0;
            chan_enable    <= 1'b0;
            lock_pulse     <= 1'b0;
        end else begin
            lock_pulse <= close_hit;
            if (close_hit) begin
                bit_divisor    <= res_div;
                rx_first_delay <= res_half;
                fast_mode      <= res_fast;
                chan_enable    <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/abd_chk.sv
module abd_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic [W-1:0] cnt_val,
    input logic         cnt_at_max,
    input logic [W-1:0] bit_divisor,
    input logic [W-1:0] rx_first_delay,
    input logic         fast_mode,
    input logic         chan_enable,
    input logic         lock_pulse,
    input logic         cts_out,
    input logic         dsr_out
);
    assert_handshake_R2: assert property (@(posedge clk) disable iff (rst)
        (cts_out == !chan_enable) && (dsr_out == !chan_enable));

    assert_no_tick_no_count_R3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_val));

    assert_lock_with_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(chan_enable) |-> lock_pulse);

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        lock_pulse |=> !lock_pulse);

    assert_trim_R5: assert property (@(posedge clk) disable iff (rst)
        (chan_enable && !fast_mode) |-> (bit_divisor == cnt_val - W'(1)));

    assert_fast_preload_R6: assert property (@(posedge clk) disable iff (rst)
        fast_mode |-> (rx_first_delay == W'(1)) && (bit_divisor == W'(1)));

    assert_saturate_R7: assert property (@(posedge clk) disable iff (rst)
        cnt_at_max |=> cnt_at_max);

    assert_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        chan_enable |=> chan_enable && $stable(bit_divisor)
                        && $stable(rx_first_delay) && $stable(fast_mode));
endmodule

bind autobaud_detector abd_chk #(.W(CNT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .tick           (tick),
    .cnt_val        (cnt_val),
    .cnt_at_max     (cnt_at_max),
    .bit_divisor    (bit_divisor),
    .rx_first_delay (rx_first_delay),
    .fast_mode      (fast_mode),
    .chan_enable    (chan_enable),
    .lock_pulse     (lock_pulse),
    .cts_out        (cts_out),
    .dsr_out        (dsr_out)
);

// File: tb/autobaud_detector_test.sv
module autobaud_detector_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick;
    logic        rxd_in;
    logic [15:0] bit_divisor;
    logic [15:0] rx_first_delay;
    logic        fast_mode;
    logic        chan_enable;
    logic        lock_pulse;
    logic        cts_out;
    logic        dsr_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    autobaud_detector uut (
        .clk            (clk),
        .rst            (rst),
        .tick           (tick),
        .rxd_in         (rxd_in),
        .bit_divisor    (bit_divisor),
        .rx_first_delay (rx_first_delay),
        .fast_mode      (fast_mode),
        .chan_enable    (chan_enable),
        .lock_pulse     (lock_pulse),
        .cts_out        (cts_out),
        .dsr_out        (dsr_out)
    );

    function automatic int sat(input int c);
        return (c > 65535) ? 65535 : c;
    endfunction
    function automatic int exp_div(input int c);
        return (sat(c) >= 2) ? sat(c) - 1 : sat(c);
    endfunction
    function automatic int exp_half(input int c);
        return (sat(c) >= 2) ? (sat(c) - 1) / 2 : 1;
    endfunction
    function automatic int exp_fast(input int c);
        return (sat(c) < 2) ? 1 : 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tick = 1'b0; rxd_in = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_ticks(input int n, input bit gaps);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
        end
    endtask

    task automatic close_and_check(input int c, input string tag);
        check({tag, " R2 cts before lock"}, int'(cts_out), 1);
        check({tag, " R2 dsr before lock"}, int'(dsr_out), 1);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        check({tag, " R4 lock_pulse"}, int'(lock_pulse), 1);
        check({tag, " R4 chan_enable"}, int'(chan_enable), 1);
        check({tag, " R5 bit_divisor"}, int'(bit_divisor), exp_div(c));
        check({tag, " R5 rx_first_delay"}, int'(rx_first_delay), exp_half(c));
        check({tag, " R6 fast_mode"}, int'(fast_mode), exp_fast(c));
        check({tag, " R2 cts after lock"}, int'(cts_out), 0);
        @(negedge clk);
        check({tag, " R4 pulse one cycle"}, int'(lock_pulse), 0);
    endtask

    task automatic measure(input int n, input int pre_high, input bit gaps, input string tag);
        do_reset();
        pulse_ticks(pre_high, gaps);   // R10 idle high ticks
        rxd_in = 1'b0;
        settle();
        pulse_ticks(n, gaps);
        rxd_in = 1'b1;
        settle();
        close_and_check(n, tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; tick = 1'b0; rxd_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 enable in reset", int'(chan_enable), 0);
        check("R1 cts in reset", int'(cts_out), 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 enable", int'(chan_enable), 0);
        check("R1 pulse", int'(lock_pulse), 0);
        check("R1 fast", int'(fast_mode), 0);
        check("R1 divisor", int'(bit_divisor), 0);
        check("R1 delay", int'(rx_first_delay), 0);
        check("R1 dsr", int'(dsr_out), 1);

        measure(1, 0, 1'b0, "R6 one tick");
        measure(2, 3, 1'b1, "R5 two ticks");
        measure(3, 0, 1'b1, "R5 three ticks");
        measure(217, 5, 1'b1, "R10 R3 with idle ticks");

        // R7 saturation, tick held continuously
        do_reset();
        rxd_in = 1'b0;
        settle();
        @(negedge clk) tick = 1'b1;
        repeat (70000) @(negedge clk);
        tick = 1'b0;
        rxd_in = 1'b1;
        settle();
        close_and_check(70000, "R7 saturation");

        // R8 frozen after lock
        measure(9, 0, 1'b1, "R8 pre");
        rxd_in = 1'b0;
        settle();
        pulse_ticks(4, 1'b1);
        rxd_in = 1'b1;
        settle();
        pulse_ticks(2, 1'b0);
        @(negedge clk);
        check("R8 divisor held", int'(bit_divisor), 8);
        check("R8 delay held", int'(rx_first_delay), 4);
        check("R8 enable held", int'(chan_enable), 1);
        check("R8 no new pulse", int'(lock_pulse), 0);

        // R9 reset coincides with closing tick
        do_reset();
        rxd_in = 1'b0;
        settle();
        pulse_ticks(5, 1'b0);
        rxd_in = 1'b1;
        settle();
        @(negedge clk) begin tick = 1'b1; rst = 1'b1; end
        @(negedge clk) begin tick = 1'b0; rst = 1'b0; end
        check("R9 no lock", int'(chan_enable), 0);
        check("R9 no pulse", int'(lock_pulse), 0);
        check("R9 divisor zero", int'(bit_divisor), 0);
        check("R9 cts high", int'(cts_out), 1);
        rxd_in = 1'b0;
        settle();
        pulse_ticks(7, 1'b1);
        rxd_in = 1'b1;
        settle();
        close_and_check(7, "R9 remeasure");

        // random runs
        for (int i = 0; i < 20; i++) begin
            int n;
            int pre;
            n   = int'($urandom_range(1, 200));
            pre = int'($urandom_range(0, 6));
            measure(n, pre, 1'b1, "R3 random");
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
            $finish;
        end
    end
endmodule